// File: doc/BRIEF.md
# Multi-Phase Stage Clock Sequencer

This block splits each I/O clock cycle into equal time slots on a fast clock and hands out one slot to each stage of a cascade of memory look-up stages. The fast clock runs at a fixed multiple of the I/O clock: the number of active phases plus one. The extra slot is left idle in every I/O cycle. It gives setup and hold margin between the I/O registers and the first and last stages of the cascade. A one-cycle sync pulse marks each I/O clock edge and realigns the slot counter. The counter runs freely between pulses, and a pulse that arrives anywhere but in the idle slot sets a sticky flag.

The cascade can be used as one chain of all stages, as two loops of half the stages, or as four loops of a quarter of the stages. In the split topologies, fewer phases are generated per I/O cycle and each phase drives one stage in every loop at the same time. The fast clock then runs at a smaller multiple. Each stage also gets a capture strobe in the fast cycle right after its enable ends. This stands for the falling-edge registration of the stage's output.

Top module: `lutseq_phase_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first sync pulse, phase_o, stage_en_o and capture_o are all zero and misalign_o is low.
- R2: A sync pulse sampled at a fast clock edge makes phase_o[0] high in the following cycle. Phases 0 to P-1 then follow one per fast cycle, and they are followed by one idle cycle in which phase_o is zero.
- R3: The phase count P depends on topo_i as latched at the last sync: 2'b00 gives NUM_STAGES, 2'b01 gives NUM_STAGES/2, 2'b10 gives NUM_STAGES/4, and 2'b11 gives NUM_STAGES.
- R4: Without further sync pulses, the sequence repeats with a period of P+1 fast cycles, idle slot included.
- R5: stage_en_o[s] is high exactly when phase_o[s mod P] is high.
- R6: capture_o[s] is high in the fast cycle right after a cycle in which stage_en_o[s] was high, and low otherwise.
- R7: topo_i is sampled only on a sync cycle. A change of topo_i between sync pulses has no effect on the outputs.
- R8: A sync pulse that arrives while the counter is running and not in the idle slot sets misalign_o one cycle later. misalign_o then stays high until reset, and the sequence realigns to phase 0.
- R9: At most one bit of phase_o is high in any cycle.
- R10: A sync pulse sampled in the idle slot, and the first sync after reset, leave misalign_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast slot clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | One-cycle pulse marking an I/O clock edge |
| topo_i | input | 2 | Cascade topology select (full, half loops, quarter loops) |
| phase_o | output | NUM_STAGES | One-hot phase enables, slot k on bit k |
| stage_en_o | output | NUM_STAGES | Per-stage evaluate enable after topology mapping |
| capture_o | output | NUM_STAGES | Per-stage capture strobe, one cycle after its enable |
| misalign_o | output | 1 | Sticky flag for a sync pulse outside the idle slot |

## Verification
Every result is due in the fast cycle right after the edge that samples sync_i and topo_i. phase_o, stage_en_o and misalign_o come from registers written at that edge. capture_o follows one further cycle behind the enable it reflects. The driver applies each input at a falling edge and computes from the requirements the outputs due after the next rising edge. The monitor compares them a quarter period after that rising edge, so each expected item is checked in exactly the cycle it belongs to. The internal reset is released two edges after rst_ni rises, so no sync is applied within the first cycles after release.

// File: rtl/lutseq_pkg.sv
package lutseq_pkg;

  typedef enum logic [1:0] {
    TOPO_FULL    = 2'b00,
    TOPO_HALF    = 2'b01,
    TOPO_QUARTER = 2'b10,
    TOPO_ALT     = 2'b11
  } topo_e;

  // Active phases per I/O cycle for a topology and a stage count.
  function automatic int unsigned phase_count(topo_e t, int unsigned n);
    case (t)
      TOPO_HALF:    return n >> 1;
      TOPO_QUARTER: return n >> 2;
      default:      return n;
    endcase
  endfunction

endpackage

// File: rtl/lutseq_rst_sync.sv
module lutseq_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_no = sh_q[DEPTH-1];

endmodule

// File: rtl/lutseq_slot_ctr.sv
module lutseq_slot_ctr
  import lutseq_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 8,
  localparam int unsigned CNT_W = $clog2(NUM_STAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  topo_e            topo_i,
  output logic [CNT_W-1:0] slot_o,
  output logic             run_o,
  output topo_e            topo_o,
  output logic             misalign_o
);

  logic [CNT_W-1:0] slot_q, slot_d;
  logic             run_q, run_d;
  logic             mis_q, mis_d;
  topo_e            topo_q, topo_d;
  logic [CNT_W-1:0] idle_slot;
  logic             at_idle;
  logic             slot_en;

  // The idle slot index equals the active phase count.
  assign idle_slot = CNT_W'(phase_count(topo_q, NUM_STAGES));
  assign at_idle   = (slot_q == idle_slot);
  assign slot_en   = sync_i | run_q;

  always_comb begin
    slot_d = slot_q;
    run_d  = run_q;
    mis_d  = mis_q;
    topo_d = topo_q;
    if (sync_i) begin
      mis_d  = mis_q | (run_q & ~at_idle);
      run_d  = 1'b1;
      slot_d = '0;
      topo_d = topo_i;
    end else if (run_q) begin
      slot_d = at_idle ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      run_q  <= 1'b0;
      mis_q  <= 1'b0;
      topo_q <= TOPO_FULL;
    end else if (slot_en) begin
      slot_q <= slot_d;
      run_q  <= run_d;
      mis_q  <= mis_d;
      topo_q <= topo_d;
    end
  end

  assign slot_o     = slot_q;
  assign run_o      = run_q;
  assign topo_o     = topo_q;
  assign misalign_o = mis_q;

endmodule

// File: rtl/lutseq_phase_map.sv
module lutseq_phase_map
  import lutseq_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 8,
  localparam int unsigned CNT_W = $clog2(NUM_STAGES + 1),
  localparam int unsigned IDX_W = $clog2(NUM_STAGES)
) (
  input  logic [CNT_W-1:0]      slot_i,
  input  logic                  run_i,
  input  topo_e                 topo_i,
  output logic [NUM_STAGES-1:0] phase_o,
  output logic [NUM_STAGES-1:0] stage_en_o
);

  logic [CNT_W-1:0] nphase;
  logic [IDX_W-1:0] loop_mask;

  assign nphase    = CNT_W'(phase_count(topo_i, NUM_STAGES));
  assign loop_mask = IDX_W'(phase_count(topo_i, NUM_STAGES) - 1);

  // One decoder per phase; slots at or above the phase count stay dark.
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_phase
    assign phase_o[k] = run_i && (slot_i == CNT_W'(k)) && (CNT_W'(k) < nphase);
  end

  // Stage s follows phase (s mod P); P is a power of two.
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic [IDX_W-1:0] src;
    assign src           = IDX_W'(s) & loop_mask;
    assign stage_en_o[s] = phase_o[src];
  end

endmodule

// File: rtl/lutseq_phase_gen.sv
module lutseq_phase_gen
  import lutseq_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 8,
  parameter int unsigned RST_SYNC_DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sync_i,
  input  logic [1:0]            topo_i,
  output logic [NUM_STAGES-1:0] phase_o,
  output logic [NUM_STAGES-1:0] stage_en_o,
  output logic [NUM_STAGES-1:0] capture_o,
  output logic                  misalign_o
);

  logic                  rst_int_n;
  logic [CNT_W-1:0]      slot;
  logic                  run;
  topo_e                 topo_act;
  logic [NUM_STAGES-1:0] cap_q, cap_d;

  lutseq_rst_sync #(.DEPTH(RST_SYNC_DEPTH)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  lutseq_slot_ctr #(.NUM_STAGES(NUM_STAGES)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .sync_i     (sync_i),
    .topo_i     (topo_e'(topo_i)),
    .slot_o     (slot),
    .run_o      (run),
    .topo_o     (topo_act),
    .misalign_o (misalign_o)
  );

  lutseq_phase_map #(.NUM_STAGES(NUM_STAGES)) u_map (
    .slot_i     (slot),
    .run_i      (run),
    .topo_i     (topo_act),
    .phase_o    (phase_o),
    .stage_en_o (stage_en_o)
  );

  // Capture strobe marks the end of each stage's evaluate slot.
  always_comb begin
    cap_d = stage_en_o;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) cap_q <= '0;
    else            cap_q <= cap_d;
  end

  assign capture_o = cap_q;

endmodule

// File: rtl/lutseq_phase_gen_chk.sv
module lutseq_phase_gen_chk
  import lutseq_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 8
) (
  input logic                  clk_i,
  input logic                  rst_n,
  input logic                  sync_i,
  input topo_e                 topo_act,
  input logic [NUM_STAGES-1:0] phase_o,
  input logic [NUM_STAGES-1:0] stage_en_o,
  input logic [NUM_STAGES-1:0] capture_o,
  input logic                  misalign_o
);

  always @(posedge clk_i) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (phase_o == '0 && capture_o == '0 && !misalign_o)
        else $error("outputs active during reset");
    end
  end

  p_sync_starts_phase0_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    sync_i |=> phase_o[0]);

  p_loop_fanout_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stage_en_o != '0) |->
      ($countones(stage_en_o) == NUM_STAGES / phase_count(topo_act, NUM_STAGES)));

  p_misalign_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    misalign_o |=> misalign_o);

  p_phase_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(phase_o));

endmodule

bind lutseq_phase_gen lutseq_phase_gen_chk #(.NUM_STAGES(NUM_STAGES)) chk_i (
  .clk_i      (clk_i),
  .rst_n      (rst_int_n),
  .sync_i     (sync_i),
  .topo_act   (topo_act),
  .phase_o    (phase_o),
  .stage_en_o (stage_en_o),
  .capture_o  (capture_o),
  .misalign_o (misalign_o)
);

// File: tb/lutseq_phase_gen_tb.sv
module lutseq_phase_gen_tb_top;

  localparam int NS = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk;
  logic          rst_n;
  logic          sync;
  logic [1:0]    topo;
  logic [NS-1:0] phase, stage_en, capture;
  logic          misalign;

  lutseq_phase_gen #(.NUM_STAGES(NS)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_i     (sync),
    .topo_i     (topo),
    .phase_o    (phase),
    .stage_en_o (stage_en),
    .capture_o  (capture),
    .misalign_o (misalign)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Scoreboard queues: packed {phase, stage_en, capture, misalign} and its tag.
  logic [3*NS:0] exp_q[$];
  string         tag_q[$];

  // Reference model state, derived from the requirements.
  int            m_run = 0;
  int            m_cnt = 0;
  int            m_p   = NS;
  logic          m_mis = 1'b0;
  logic [NS-1:0] m_en  = '0;

  function automatic int pcount(logic [1:0] m);
    case (m)
      2'b01:   return NS / 2;
      2'b10:   return NS / 4;
      default: return NS;
    endcase
  endfunction

  task automatic step(input logic s, input logic [1:0] m, input string tag);
    logic [NS-1:0] ph;
    logic [NS-1:0] en;
    logic [NS-1:0] cp;
    @(negedge clk);
    sync = s;
    topo = m;
    cp = m_en;
    if (s) begin
      if (m_run != 0 && m_cnt != m_p) m_mis = 1'b1;
      m_run = 1;
      m_cnt = 0;
      m_p   = pcount(m);
    end else if (m_run != 0) begin
      m_cnt = (m_cnt == m_p) ? 0 : m_cnt + 1;
    end
    ph = '0;
    if (m_run != 0 && m_cnt < m_p) ph[m_cnt] = 1'b1;
    en = '0;
    for (int i = 0; i < NS; i++) if (ph[i % m_p]) en[i] = 1'b1;
    m_en = en;
    exp_q.push_back({ph, en, cp, m_mis});
    tag_q.push_back(tag);
  endtask

  task automatic periods(input logic [1:0] m, input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      step(1'b1, m, tag);
      repeat (pcount(m)) step(1'b0, m, tag);
    end
  endtask

  // Monitor: compares a quarter period after each rising edge.
  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (exp_q.size() != 0) begin
      logic [3*NS:0] e;
      string t;
      bit bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      bad = 0;
      n_vec++;
      if (phase !== e[3*NS:2*NS+1]) begin
        bad = 1;
        $display("FAIL %s R2/R9 phase: got %b exp %b", t, phase, e[3*NS:2*NS+1]);
      end
      if (stage_en !== e[2*NS:NS+1]) begin
        bad = 1;
        $display("FAIL %s R5 stage_en: got %b exp %b", t, stage_en, e[2*NS:NS+1]);
      end
      if (capture !== e[NS:1]) begin
        bad = 1;
        $display("FAIL %s R6 capture: got %b exp %b", t, capture, e[NS:1]);
      end
      if (misalign !== e[0]) begin
        bad = 1;
        $display("FAIL %s R8/R10 misalign: got %b exp %b", t, misalign, e[0]);
      end
      if (bad) n_fail++;
    end
  end

  initial begin
    rst_n = 1'b0;
    sync  = 1'b0;
    topo  = 2'b00;
    // R1: quiet during reset and until the first sync
    repeat (4) step(1'b0, 2'b00, "R1");
    rst_n = 1'b1;
    repeat (5) step(1'b0, 2'b00, "R1");
    // R2 / R10: full chain, syncs on the idle slot
    periods(2'b00, 3, "R2");
    // R4 / R7: free run, topo_i changed without sync
    repeat (14) step(1'b0, 2'b01, "R4_R7");
    while (m_cnt != m_p) step(1'b0, 2'b00, "R4");
    // R3 / R5: split topologies
    periods(2'b01, 2, "R5");
    periods(2'b10, 3, "R3");
    periods(2'b11, 1, "R3");
    periods(2'b00, 1, "R10");
    // R8: early sync, then sticky flag
    step(1'b1, 2'b00, "R8");
    step(1'b0, 2'b00, "R8");
    step(1'b0, 2'b00, "R8");
    step(1'b1, 2'b10, "R8");
    repeat (4) step(1'b0, 2'b10, "R8");
    periods(2'b10, 2, "R8");
    step(1'b0, 2'b10, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule